// File: doc/BRIEF.md
# Indexed Base-Displacement Word Load Unit

This block carries out one 32-bit word load per start strobe. The instruction word names a target register, an optional index register, an optional base register and a 12-bit unsigned displacement. The unit reads the two address registers from an external 16 x 32 register file and adds them to the displacement to form a 24-bit effective address. It checks that address for range and word alignment, then issues a single read on a request/valid memory port whose response carries a 4-bit storage key. The result is either a write of the loaded word into the target register or exactly one exception flag, reported together with a one-cycle `done` pulse. The condition code is not touched: it flows from input to output unchanged.

The sequencer has six states. `S_IDLE` waits for `start`. When the opcode is not 0x58 it moves straight to `S_FINISH` with the unsupported flag set. Otherwise it latches the fields and goes to `S_ADDR`. `S_ADDR` registers the effective address and moves to `S_CHECK`. `S_CHECK` moves to `S_FINISH` on a range or alignment fault and to `S_ISSUE` when there is none. `S_ISSUE` pulses the memory request and moves to `S_WAIT`. `S_WAIT` stays there until `mem_valid`, then captures the data, performs the key comparison and moves to `S_FINISH`. `S_FINISH` drives `done` and either the register write or a flag, then returns to `S_IDLE`.

Top module: `idx_load_unit`

## Requirements
- R1: Instruction fields are opcode in bits 31:24 (load = 0x58), target register number in bits 23:20, index register number in bits 19:16, base register number in bits 15:12 and unsigned displacement in bits 11:0.
- R2: The effective address is (base value if the base field is nonzero, else 0) + (index value if the index field is nonzero, else 0) + zero-extended displacement, taken modulo 2^24.
- R3: With no fault, exactly one memory read is requested at the effective address, and the full 32-bit returned word is written to the target register in the `done` cycle.
- R4: An effective address at or above MEM_BYTES (default 65536) raises `exc_addr`. No memory read is issued and no register is written.
- R5: An effective address whose two low bits are not 00 raises `exc_align`. No memory read is issued and no register is written.
- R6: When the program key (latched at start) is nonzero and differs from the storage key returned with the data, `exc_prot` is raised and no register is written. A program key of 0 always passes.
- R7: At most one exception flag is raised per instruction. Addressing takes priority over alignment, and alignment takes priority over protection.
- R8: An opcode other than 0x58 raises `exc_unsup` with `done` one cycle after the start edge. No memory read is issued and no register is written.
- R9: `done` is high for exactly one cycle per accepted instruction. Counting clock edges from the one that samples `start`, it comes 1 edge later for unsupported opcodes, 3 edges later for range or alignment faults, and 4 + L edges later otherwise, where L is the number of cycles from the request to `mem_valid`.
- R10: `start` is ignored while `busy` is high.
- R11: `cc_out` always equals `cc_in`.
- R12: `mem_req` is a single-cycle pulse, and the unit waits any number of cycles for `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled in idle |
| instr | input | 32 | Instruction word |
| prog_key | input | 4 | Current program key |
| cc_in | input | 2 | Condition code in |
| cc_out | output | 2 | Condition code out (pass-through) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| exc_addr | output | 1 | Addressing (range) exception |
| exc_align | output | 1 | Alignment exception |
| exc_prot | output | 1 | Protection exception |
| exc_unsup | output | 1 | Unsupported opcode |
| rf_raddr_base | output | 4 | Register file read address for base |
| rf_rdata_base | input | 32 | Base register value |
| rf_raddr_idx | output | 4 | Register file read address for index |
| rf_rdata_idx | input | 32 | Index register value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write address |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 24 | Memory read byte address |
| mem_valid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory read data |
| mem_key | input | 4 | Storage key of the read location |

## Verification
The bench sweeps every base and index field against several displacements, with register 0 holding a nonzero value. A design that used register 0 instead of zero would then form wrong addresses and request the wrong location. Register values are chosen so that the sums wrap past 2^24, land just beyond the memory top and come out misaligned. A design with wrong arithmetic width, a wrong limit comparison or a missing pre-read check would issue a stray request, raise the wrong flag, or raise a second flag where two faults coincide. The program key is swept over zero, the matching key and a mismatching key, so a design that lets key 0 fail or a mismatch through gets caught. Every non-load opcode is tried, and `start` is held during a busy load, so that a second accepted command or a side effect of an unsupported opcode would be seen at the ports.

// File: rtl/ilu_pkg.sv
package ilu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CHECK,
        S_ISSUE,
        S_WAIT,
        S_FINISH
    } ilu_state_e;

    localparam int          OPC_W    = 8;
    localparam logic [7:0]  OPC_LOAD = 8'h58;

    typedef struct packed {
        logic addr;
        logic align;
        logic prot;
        logic unsup;
    } ilu_fault_t;

endpackage

// File: rtl/ilu_decode.sv
module ilu_decode #(
    parameter int RN_W   = 4,
    parameter int DISP_W = 12,
    localparam int FIELD_W = 3 * RN_W + DISP_W
) (
    input  logic [FIELD_W-1:0] fields,
    output logic [RN_W-1:0]    tgt,
    output logic [RN_W-1:0]    idx,
    output logic [RN_W-1:0]    base,
    output logic [DISP_W-1:0]  disp
);
    assign disp = fields[DISP_W-1:0];
    assign base = fields[DISP_W +: RN_W];
    assign idx  = fields[DISP_W + RN_W +: RN_W];
    assign tgt  = fields[DISP_W + 2*RN_W +: RN_W];
endmodule

// File: rtl/ilu_agen.sv
module ilu_agen #(
    parameter int DATA_W       = 32,
    parameter int AW           = 24,
    parameter int RN_W         = 4,
    parameter int DISP_W       = 12,
    parameter bit BASE0_IS_NIL = 1'b1
) (
    input  logic [RN_W-1:0]   base_num,
    input  logic [DATA_W-1:0] base_val,
    input  logic [RN_W-1:0]   idx_num,
    input  logic [DATA_W-1:0] idx_val,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     ea
);
    logic [DATA_W-1:0] base_term;
    logic [DATA_W-1:0] idx_term;
    logic [DATA_W-1:0] sum;

    generate
        if (BASE0_IS_NIL) begin : g_base_nil
            assign base_term = (base_num == '0) ? '0 : base_val;
        end else begin : g_base_raw
            logic unused_base_num;
            assign unused_base_num = &{1'b0, base_num};
            assign base_term = base_val;
        end
    endgenerate

    assign idx_term = (idx_num == '0) ? '0 : idx_val;
    assign sum      = base_term + idx_term + DATA_W'(disp);
    assign ea       = sum[AW-1:0];

    logic unused_sum_hi;
    assign unused_sum_hi = &{1'b0, sum[DATA_W-1:AW]};
endmodule

// File: rtl/ilu_check.sv
module ilu_check #(
    parameter int AW         = 24,
    parameter int DATA_W     = 32,
    parameter int KEY_W      = 4,
    parameter int MEM_BYTES  = 65536,
    localparam int WORD_B    = DATA_W / 8,
    localparam int ALIGN_LSB = $clog2(WORD_B)
) (
    input  logic [AW-1:0]    ea,
    input  logic [KEY_W-1:0] prog_key,
    input  logic [KEY_W-1:0] stor_key,
    output logic             range_fault,
    output logic             align_fault,
    output logic             key_fault
);
    localparam logic [AW:0] MEM_LIMIT = (AW+1)'(MEM_BYTES);

    assign range_fault = {1'b0, ea} >= MEM_LIMIT;
    assign align_fault = |ea[ALIGN_LSB-1:0];
    assign key_fault   = (prog_key != '0) && (prog_key != stor_key);
endmodule

// File: rtl/idx_load_unit.sv
module idx_load_unit
    import ilu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AW        = 24,
    parameter int RN_W      = 4,
    parameter int DISP_W    = 12,
    parameter int KEY_W     = 4,
    parameter int CC_W      = 2,
    parameter int MEM_BYTES = 65536,
    localparam int FIELD_W  = 3 * RN_W + DISP_W,
    localparam int INSTR_W  = OPC_W + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [KEY_W-1:0]   prog_key,
    input  logic [CC_W-1:0]    cc_in,
    output logic [CC_W-1:0]    cc_out,
    output logic               busy,
    output logic               done,
    output logic               exc_addr,
    output logic               exc_align,
    output logic               exc_prot,
    output logic               exc_unsup,
    output logic [RN_W-1:0]    rf_raddr_base,
    input  logic [DATA_W-1:0]  rf_rdata_base,
    output logic [RN_W-1:0]    rf_raddr_idx,
    input  logic [DATA_W-1:0]  rf_rdata_idx,
    output logic               rf_we,
    output logic [RN_W-1:0]    rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_valid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [KEY_W-1:0]   mem_key
);
    ilu_state_e          state_q, state_d;
    logic [FIELD_W-1:0]  fields_q;
    logic [KEY_W-1:0]    key_q;
    logic [AW-1:0]       ea_q;
    logic [DATA_W-1:0]   data_q;
    ilu_fault_t          fault_q;

    logic [RN_W-1:0]     f_tgt, f_idx, f_base;
    logic [DISP_W-1:0]   f_disp;
    logic [AW-1:0]       ea_d;
    logic                range_f, align_f, key_f;
    logic                opc_ok;

    assign opc_ok = (instr[INSTR_W-1 -: OPC_W] == OPC_LOAD);

    ilu_decode #(.RN_W(RN_W), .DISP_W(DISP_W)) u_dec (
        .fields (fields_q),
        .tgt    (f_tgt),
        .idx    (f_idx),
        .base   (f_base),
        .disp   (f_disp)
    );

    ilu_agen #(
        .DATA_W(DATA_W), .AW(AW), .RN_W(RN_W), .DISP_W(DISP_W), .BASE0_IS_NIL(1'b1)
    ) u_agen (
        .base_num (f_base),
        .base_val (rf_rdata_base),
        .idx_num  (f_idx),
        .idx_val  (rf_rdata_idx),
        .disp     (f_disp),
        .ea       (ea_d)
    );

    ilu_check #(
        .AW(AW), .DATA_W(DATA_W), .KEY_W(KEY_W), .MEM_BYTES(MEM_BYTES)
    ) u_chk_logic (
        .ea          (ea_q),
        .prog_key    (key_q),
        .stor_key    (mem_key),
        .range_fault (range_f),
        .align_fault (align_f),
        .key_fault   (key_f)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = opc_ok ? S_ADDR : S_FINISH;
            S_ADDR:   state_d = S_CHECK;
            S_CHECK:  state_d = (range_f || align_f) ? S_FINISH : S_ISSUE;
            S_ISSUE:  state_d = S_WAIT;
            S_WAIT:   if (mem_valid) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
            key_q    <= '0;
            ea_q     <= '0;
            data_q   <= '0;
            fault_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    fields_q      <= instr[FIELD_W-1:0];
                    key_q         <= prog_key;
                    fault_q       <= '0;
                    fault_q.unsup <= !opc_ok;
                end
                S_ADDR:  ea_q <= ea_d;
                S_CHECK: begin
                    fault_q.addr  <= range_f;
                    fault_q.align <= align_f && !range_f;
                end
                S_WAIT: if (mem_valid) begin
                    data_q       <= mem_rdata;
                    fault_q.prot <= key_f;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != S_IDLE);
        done          = (state_q == S_FINISH);
        exc_addr      = done && fault_q.addr;
        exc_align     = done && fault_q.align;
        exc_prot      = done && fault_q.prot;
        exc_unsup     = done && fault_q.unsup;
        rf_we         = done && (fault_q == '0);
        rf_waddr      = f_tgt;
        rf_wdata      = data_q;
        rf_raddr_base = f_base;
        rf_raddr_idx  = f_idx;
        mem_req       = (state_q == S_ISSUE);
        mem_addr      = ea_q;
        cc_out        = cc_in;
    end
endmodule

// File: rtl/ilu_checker.sv
module ilu_checker #(
    parameter int AW        = 24,
    parameter int INSTR_W   = 32,
    parameter int CC_W      = 2,
    parameter int MEM_BYTES = 65536
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [INSTR_W-1:0] instr,
    input logic [CC_W-1:0]    cc_in,
    input logic [CC_W-1:0]    cc_out,
    input logic               busy,
    input logic               done,
    input logic               exc_addr,
    input logic               exc_align,
    input logic               exc_prot,
    input logic               exc_unsup,
    input logic               rf_we,
    input logic               mem_req,
    input logic [AW-1:0]      mem_addr
);
    localparam logic [AW:0] LIMIT = (AW+1)'(MEM_BYTES);
    logic any_exc;
    assign any_exc = exc_addr | exc_align | exc_prot | exc_unsup;

    assert_one_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_addr, exc_align, exc_prot, exc_unsup}));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flag_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_exc |-> done);

    assert_clean_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (done && !any_exc));

    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_req_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr} < LIMIT));

    assert_req_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_cc_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cc_out == cc_in);

    assert_unsup_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && instr[INSTR_W-1 -: 8] != 8'h58) |=> (done && exc_unsup));
endmodule

bind idx_load_unit ilu_checker #(
    .AW(AW), .INSTR_W(INSTR_W), .CC_W(CC_W), .MEM_BYTES(MEM_BYTES)
) u_ilu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .instr     (instr),
    .cc_in     (cc_in),
    .cc_out    (cc_out),
    .busy      (busy),
    .done      (done),
    .exc_addr  (exc_addr),
    .exc_align (exc_align),
    .exc_prot  (exc_prot),
    .exc_unsup (exc_unsup),
    .rf_we     (rf_we),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr)
);

// File: tb/idx_load_unit_tb.sv
module idx_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  prog_key = '0;
    logic [1:0]  cc_in = '0;
    logic [1:0]  cc_out;
    logic        busy, done, exc_addr, exc_align, exc_prot, exc_unsup;
    logic [3:0]  rf_raddr_base, rf_raddr_idx, rf_waddr;
    logic [31:0] rf_rdata_base, rf_rdata_idx, rf_wdata;
    logic        rf_we, mem_req;
    logic [23:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_key = '0;

    logic [31:0] rf [16];
    int nchk = 0, nerr = 0;
    int lat = 1;
    int req_total = 0;
    logic [23:0] last_req_addr = '0;
    bit pend = 0;
    int cnt = 0;

    always #4 clk = ~clk;

    assign rf_rdata_base = rf[rf_raddr_base];
    assign rf_rdata_idx  = rf[rf_raddr_idx];

    idx_load_unit u_dut (.*);

    function automatic logic [31:0] memf(input logic [23:0] a);
        return {8'hA5, a} ^ 32'h0F0F_3C00;
    endfunction
    function automatic logic [3:0] keyf(input logic [23:0] a);
        return a[5:2] ^ a[9:6];
    endfunction
    function automatic logic [31:0] rf_init(input int k);
        if (k == 0)  return 32'h0000_0100;
        if (k == 13) return 32'h00FF_FFFC;
        if (k == 14) return 32'h0100_0004;
        if (k == 15) return 32'h0000_FFFC;
        return k * 32'h0000_0F40 + ((k % 4 == 3) ? 32'd1 : 32'd0);
    endfunction

    task automatic reset_rf();
        for (int k = 0; k < 16; k++) rf[k] = rf_init(k);
    endtask

    // memory responder, driven at the falling edge
    always @(negedge clk) begin
        if (mem_valid) mem_valid = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mem_valid = 1'b1;
                mem_rdata = memf(last_req_addr);
                mem_key   = keyf(last_req_addr);
                pend = 0;
            end else cnt = cnt - 1;
        end else if (mem_req && rst_n) begin
            req_total++;
            last_req_addr = mem_addr;
            pend = 1;
            cnt = lat;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // observed results of the last instruction
    int o_cyc, o_reqs;
    logic [3:0] o_flags;
    logic o_we, o_pulse_ok;
    logic [3:0] o_waddr;
    logic [31:0] o_wdata;
    logic [1:0] o_cc, o_ccexp;

    task automatic issue(input logic [31:0] ins, input logic [3:0] pk, input logic [1:0] cc);
        int r0;
        @(negedge clk);
        r0 = req_total;
        instr = ins; prog_key = pk; cc_in = cc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        o_cyc = 1;
        while (!done && o_cyc < 100) begin
            @(negedge clk);
            o_cyc++;
        end
        o_flags = {exc_addr, exc_align, exc_prot, exc_unsup};
        o_we = rf_we; o_waddr = rf_waddr; o_wdata = rf_wdata;
        o_cc = cc_out; o_ccexp = cc_in;
        @(negedge clk);
        o_pulse_ok = !done;
        o_reqs = req_total - r0;
        if (o_we) rf[o_waddr] = o_wdata;
    endtask

    task automatic do_load(input int tgt, input int ix, input int bs, input int disp,
                           input int pkmode, input int l);
        logic [31:0] bv, xv, s;
        logic [23:0] ea;
        logic [3:0]  pk, sk, ef;
        bit e_a, e_l, e_p, clean;
        string tag;
        reset_rf();
        lat = l;
        bv = (bs == 0) ? 32'd0 : rf[bs];
        xv = (ix == 0) ? 32'd0 : rf[ix];
        s  = bv + xv + 32'(disp);
        ea = s[23:0];
        sk = keyf(ea);
        pk = (pkmode == 0) ? 4'd0 : (pkmode == 1) ? sk : (sk ^ 4'h5);
        e_a = (ea >= 24'd65536);
        e_l = !e_a && (ea[1:0] != 2'b00);
        e_p = !e_a && !e_l && (pk != 4'd0) && (pk != sk);
        clean = !e_a && !e_l && !e_p;
        ef = {e_a, e_l, e_p, 1'b0};
        tag = e_a ? ((ea[1:0] != 0) ? "R7" : "R4") : e_l ? "R5" : e_p ? "R6" : "R3";
        issue({8'h58, 4'(tgt), 4'(ix), 4'(bs), 12'(disp)}, pk, 2'(tgt ^ disp));
        chk(o_flags == ef, tag, "flags", o_flags, ef);
        chk(o_cyc == ((e_a || e_l) ? 3 : 4 + l), "R9", "done latency", o_cyc,
            (e_a || e_l) ? 3 : 4 + l);
        chk(o_pulse_ok, "R9", "done single pulse", !o_pulse_ok, 0);
        chk(o_reqs == ((e_a || e_l) ? 0 : 1), "R12", "request count", o_reqs,
            (e_a || e_l) ? 0 : 1);
        if (!e_a && !e_l)
            chk(last_req_addr == ea, "R2", "effective address (R1 fields)", last_req_addr, ea);
        chk(o_we == clean, "R3", "write enable", o_we, clean);
        if (clean) begin
            chk(o_waddr == 4'(tgt), "R1", "target register", o_waddr, tgt);
            chk(o_wdata == memf(ea), "R3", "written word", o_wdata, memf(ea));
        end
        chk(o_cc == o_ccexp, "R11", "condition code", o_cc, o_ccexp);
    endtask

    initial begin
        int n;
        reset_rf();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({done, busy, mem_req, rf_we, exc_addr, exc_align, exc_prot, exc_unsup} == 8'h00,
            "R9", "reset outputs",
            {done, busy, mem_req, rf_we, exc_addr, exc_align, exc_prot, exc_unsup}, 0);
        rst_n = 1'b1;

        // full sweep of base and index fields
        n = 0;
        for (int bs = 0; bs < 16; bs++)
            for (int ix = 0; ix < 16; ix++)
                for (int d = 0; d < 4; d++) begin
                    int disp;
                    disp = (d == 0) ? 0 : (d == 1) ? 4 : (d == 2) ? 12'hFFF : 12'h802;
                    do_load((bs + ix + d) % 16, ix, bs, disp, n % 3, 1 + (n % 4));
                    n++;
                end

        // long memory latency, R12
        do_load(5, 0, 1, 8, 0, 37);

        // every other opcode, R8
        for (int o = 0; o < 256; o++) begin
            if (o != 8'h58) begin
                reset_rf();
                issue({8'(o), 24'h123456}, 4'h0, 2'(o));
                chk(o_flags == 4'b0001, "R8", "unsupported flag", o_flags, 1);
                chk(o_cyc == 1 && o_reqs == 0 && !o_we, "R8", "no side effect",
                    {o_cyc, o_reqs, 32'(o_we)}, 1);
            end
        end

        // start held while busy, R10
        begin
            int dones, cyc, reqs0;
            reset_rf();
            lat = 3;
            @(negedge clk);
            reqs0 = req_total;
            instr = {8'h58, 4'd7, 4'd0, 4'd1, 12'd0}; prog_key = 0; start = 1'b1;
            @(negedge clk);
            instr = {8'h00, 24'h000000};
            dones = 0; cyc = 1;
            for (int i = 0; i < 20; i++) begin
                if (i == 3) start = 1'b0;
                if (done) begin
                    dones++;
                    chk(cyc == 7 && rf_we && rf_waddr == 4'd7 && !exc_unsup, "R10",
                        "first command completes", cyc, 7);
                    chk(rf_wdata == memf(24'h000F40), "R10", "loaded word", rf_wdata,
                        memf(24'h000F40));
                end
                @(negedge clk);
                cyc++;
            end
            chk(dones == 1, "R10", "done count", dones, 1);
            chk(req_total - reqs0 == 1, "R10", "request count", req_total - reqs0, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R9 watchdog expired: actual=hung expected=complete");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule